// File: doc/BRIEF.md
# PCI IDE Controller Configuration Register File

This block is the configuration register space of a single-function PCI IDE mass-storage controller. A configuration agent upstream decodes bus cycles and presents the block with a function number, an 8-bit byte address, a write strobe with one data byte, and takes back one byte of read data. The block holds the fixed identification bytes and applies a separate write rule to each writable byte. Only function 0 is implemented.

The command byte's I/O-enable bit drives the decode enables of the two legacy IDE channels. The programming-interface byte can be changed only when its capability bits allow it. When it can be changed, it sets one interrupt-mode flag per channel. A build parameter states which channels exist, and an absent channel never decodes. A 16-byte window of vendor scratch bytes is fully read/write. Every other byte is read-only.

Top module: `ide_cfg_space`

## Requirements
- R1: After synchronous reset, function-0 reads return 0x42 at 0x00, 0x10 at 0x01, 0x00 at 0x02, 0x10 at 0x03, 0x02 at 0x07, 0x02 (revision) at 0x08, 0x01 at 0x0A, 0x01 at 0x0B, 0x0E (line 14) at 0x3C and 0x01 (INTA) at 0x3D. Every other byte, including 0x04 and 0x40–0x4F, reads 0x00.
- R2: After reset, byte 0x09 reads the value of parameter PROGIF_INIT, and both interrupt-mode outputs are low.
- R3: Any read with a function number other than 0 returns 0xFF. Any write with a function number other than 0 changes nothing.
- R4: A write to byte 0x04 stores only bits 6 and 0 of the data (mask 0x41). The other bits read back as 0.
- R5: A write to byte 0x07 clears stored bit 7 when data bit 7 is 1 and leaves bits 6:0 unchanged. Writing 0xFF after reset therefore reads back 0x02.
- R6: A write to byte 0x09 takes effect only when stored bits 1 and 3 are both 1. The new value is then (stored & 0x0A) | (data & 0x05). Otherwise the byte and both interrupt-mode outputs are unchanged.
- R7: A write to byte 0x09 that takes effect sets pri_native to data bit 0 and sec_native to data bit 2.
- R8: Bytes 0x40 through 0x4F store and return the full written byte.
- R9: A function-0 write to any byte not named in R4–R8 (for example 0x00, 0x3C, 0x3F, 0x50) changes nothing.
- R10: pri_cmd_base is 0x01F0, pri_ctl_port is 0x03F6, sec_cmd_base is 0x0170 and sec_ctl_port is 0x0376.
- R11: The enable of a present channel equals stored bit 0 of byte 0x04. It follows a write from the clock edge that takes the write onward.
- R12: CHAN_PRESENT bit 0 marks the primary channel and bit 1 the secondary. The enable of an absent channel is low at all times.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_func | input | 3 | Function number of the access |
| cfg_addr | input | 8 | Configuration byte address |
| cfg_wdata | input | 8 | Write data byte |
| cfg_we | input | 1 | Write strobe, acts on the rising clock edge |
| cfg_rdata | output | 8 | Read data, combinational from cfg_func and cfg_addr |
| pri_en | output | 1 | Primary channel decode enable |
| pri_cmd_base | output | 16 | Primary command-block I/O base |
| pri_ctl_port | output | 16 | Primary control-port I/O address |
| pri_native | output | 1 | Primary interrupt-mode flag |
| sec_en | output | 1 | Secondary channel decode enable |
| sec_cmd_base | output | 16 | Secondary command-block I/O base |
| sec_ctl_port | output | 16 | Secondary control-port I/O address |
| sec_native | output | 1 | Secondary interrupt-mode flag |

## Verification
A write is stored on the one rising edge where cfg_we is high. Read data comes combinationally from the stored state, so the new value appears on cfg_rdata straight after that edge, with no added latency. The channel enables and interrupt-mode flags are driven straight from the same registers, so they also change at that edge. The bench drives every access at a falling edge and holds the strobe for one rising edge. It drops the strobe at the next falling edge and samples reads and flag outputs 1 ns later, well away from either edge.

// File: rtl/ide_cfg_pkg.sv
package ide_cfg_pkg;
    localparam int FUNC_W = 3;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 8;
    localparam int PORT_W = 16;
    localparam int NUM_CHAN = 2;

    // Byte addresses whose meaning the bus agent and software decode
    localparam logic [ADDR_W-1:0] A_VEND0    = 8'h00;
    localparam logic [ADDR_W-1:0] A_VEND1    = 8'h01;
    localparam logic [ADDR_W-1:0] A_DEV0     = 8'h02;
    localparam logic [ADDR_W-1:0] A_DEV1     = 8'h03;
    localparam logic [ADDR_W-1:0] A_CMD      = 8'h04;
    localparam logic [ADDR_W-1:0] A_STAT_HI  = 8'h07;
    localparam logic [ADDR_W-1:0] A_REV      = 8'h08;
    localparam logic [ADDR_W-1:0] A_PROGIF   = 8'h09;
    localparam logic [ADDR_W-1:0] A_SUBCLASS = 8'h0A;
    localparam logic [ADDR_W-1:0] A_CLASS    = 8'h0B;
    localparam logic [ADDR_W-1:0] A_INT_LINE = 8'h3C;
    localparam logic [ADDR_W-1:0] A_INT_PIN  = 8'h3D;

    // Fixed contents
    localparam logic [DATA_W-1:0] V_VEND0    = 8'h42;
    localparam logic [DATA_W-1:0] V_VEND1    = 8'h10;
    localparam logic [DATA_W-1:0] V_DEV0     = 8'h00;
    localparam logic [DATA_W-1:0] V_DEV1     = 8'h10;
    localparam logic [DATA_W-1:0] V_REV      = 8'h02;
    localparam logic [DATA_W-1:0] V_SUBCLASS = 8'h01;
    localparam logic [DATA_W-1:0] V_CLASS    = 8'h01;
    localparam logic [DATA_W-1:0] V_INT_LINE = 8'd14;
    localparam logic [DATA_W-1:0] V_INT_PIN  = 8'h01;

    // Write rules
    localparam logic [DATA_W-1:0] CMD_WMASK    = 8'h41;
    localparam logic [DATA_W-1:0] STAT_W1C     = 8'h80;
    localparam logic [DATA_W-1:0] STAT_INIT    = 8'h02;
    localparam logic [DATA_W-1:0] PROGIF_LOCK  = 8'h0A;
    localparam logic [DATA_W-1:0] PROGIF_WMASK = 8'h05;
    localparam int PROGIF_PRI_BIT = 0;
    localparam int PROGIF_SEC_BIT = 2;
    localparam int CMD_IO_BIT     = 0;

    // Scratch window
    localparam int SCRATCH_BASE  = 'h40;
    localparam int SCRATCH_DEPTH = 16;
    localparam int SCRATCH_IDX_W = $clog2(SCRATCH_DEPTH);

    typedef struct packed {
        logic              we;
        logic [FUNC_W-1:0] func;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } cfg_req_t;

    function automatic logic [PORT_W-1:0] chan_cmd_base(input int ch);
        return (ch == 0) ? 16'h01F0 : 16'h0170;
    endfunction

    function automatic logic [PORT_W-1:0] chan_ctl_port(input int ch);
        return (ch == 0) ? 16'h03F6 : 16'h0376;
    endfunction
endpackage

// File: rtl/ide_cfg_store.sv
module ide_cfg_store
    import ide_cfg_pkg::*;
#(
    parameter logic [7:0] PROGIF_INIT = 8'h8A
) (
    input  logic                                clk,
    input  logic                                rst,
    input  cfg_req_t                            req,
    output logic [DATA_W-1:0]                   cmd_q,
    output logic [DATA_W-1:0]                   stat_q,
    output logic [DATA_W-1:0]                   progif_q,
    output logic [NUM_CHAN-1:0]                 native_q,
    output logic [SCRATCH_DEPTH-1:0][DATA_W-1:0] scratch_q
);
    logic wr_ok;
    logic progif_open;

    assign wr_ok       = req.we && (req.func == '0);
    assign progif_open = ((progif_q & PROGIF_LOCK) == PROGIF_LOCK);

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q <= '0;
        end else if (wr_ok && req.addr == A_CMD) begin
            cmd_q <= req.data & CMD_WMASK;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stat_q <= STAT_INIT;
        end else if (wr_ok && req.addr == A_STAT_HI) begin
            stat_q <= stat_q & ~(req.data & STAT_W1C);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            progif_q <= PROGIF_INIT;
            native_q <= '0;
        end else if (wr_ok && req.addr == A_PROGIF && progif_open) begin
            progif_q    <= (progif_q & PROGIF_LOCK) | (req.data & PROGIF_WMASK);
            native_q[0] <= req.data[PROGIF_PRI_BIT];
            native_q[1] <= req.data[PROGIF_SEC_BIT];
        end
    end

    for (genvar i = 0; i < SCRATCH_DEPTH; i++) begin : g_scratch
        localparam logic [ADDR_W-1:0] SLOT = ADDR_W'(SCRATCH_BASE + i);
        always_ff @(posedge clk) begin
            if (rst) begin
                scratch_q[i] <= '0;
            end else if (wr_ok && req.addr == SLOT) begin
                scratch_q[i] <= req.data;
            end
        end
    end
endmodule

// File: rtl/ide_cfg_rdmux.sv
module ide_cfg_rdmux
    import ide_cfg_pkg::*;
(
    input  logic [FUNC_W-1:0]                   func,
    input  logic [ADDR_W-1:0]                   addr,
    input  logic [DATA_W-1:0]                   cmd_q,
    input  logic [DATA_W-1:0]                   stat_q,
    input  logic [DATA_W-1:0]                   progif_q,
    input  logic [SCRATCH_DEPTH-1:0][DATA_W-1:0] scratch_q,
    output logic [DATA_W-1:0]                   rdata
);
    logic                     in_scratch;
    logic [SCRATCH_IDX_W-1:0] sidx;
    logic [ADDR_W-1:0]        rel;

    assign rel        = addr - ADDR_W'(SCRATCH_BASE);
    assign in_scratch = (int'(addr) >= SCRATCH_BASE) &&
                        (int'(addr) < SCRATCH_BASE + SCRATCH_DEPTH);
    assign sidx       = rel[SCRATCH_IDX_W-1:0];

    always_comb begin
        rdata = '0;
        if (func != '0) begin
            rdata = '1;
        end else if (in_scratch) begin
            rdata = scratch_q[sidx];
        end else begin
            unique case (addr)
                A_VEND0:    rdata = V_VEND0;
                A_VEND1:    rdata = V_VEND1;
                A_DEV0:     rdata = V_DEV0;
                A_DEV1:     rdata = V_DEV1;
                A_CMD:      rdata = cmd_q;
                A_STAT_HI:  rdata = stat_q;
                A_REV:      rdata = V_REV;
                A_PROGIF:   rdata = progif_q;
                A_SUBCLASS: rdata = V_SUBCLASS;
                A_CLASS:    rdata = V_CLASS;
                A_INT_LINE: rdata = V_INT_LINE;
                A_INT_PIN:  rdata = V_INT_PIN;
                default:    rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/ide_chan_decode.sv
module ide_chan_decode
    import ide_cfg_pkg::*;
#(
    parameter logic [NUM_CHAN-1:0] CHAN_PRESENT = 2'b11
) (
    input  logic                           io_enable,
    output logic [NUM_CHAN-1:0]            chan_en,
    output logic [NUM_CHAN-1:0][PORT_W-1:0] cmd_base,
    output logic [NUM_CHAN-1:0][PORT_W-1:0] ctl_port
);
    for (genvar ch = 0; ch < NUM_CHAN; ch++) begin : g_chan
        assign cmd_base[ch] = chan_cmd_base(ch);
        assign ctl_port[ch] = chan_ctl_port(ch);
        if (CHAN_PRESENT[ch]) begin : g_present
            assign chan_en[ch] = io_enable;
        end else begin : g_absent
            assign chan_en[ch] = 1'b0;
        end
    end
endmodule

// File: rtl/ide_cfg_space.sv
module ide_cfg_space
    import ide_cfg_pkg::*;
#(
    parameter logic [1:0] CHAN_PRESENT = 2'b11,
    parameter logic [7:0] PROGIF_INIT  = 8'h8A
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [2:0]  cfg_func,
    input  logic [7:0]  cfg_addr,
    input  logic [7:0]  cfg_wdata,
    input  logic        cfg_we,
    output logic [7:0]  cfg_rdata,
    output logic        pri_en,
    output logic [15:0] pri_cmd_base,
    output logic [15:0] pri_ctl_port,
    output logic        pri_native,
    output logic        sec_en,
    output logic [15:0] sec_cmd_base,
    output logic [15:0] sec_ctl_port,
    output logic        sec_native
);
    cfg_req_t                             req;
    logic [DATA_W-1:0]                    cmd_q;
    logic [DATA_W-1:0]                    stat_q;
    logic [DATA_W-1:0]                    progif_q;
    logic [NUM_CHAN-1:0]                  native_q;
    logic [SCRATCH_DEPTH-1:0][DATA_W-1:0] scratch_q;
    logic [NUM_CHAN-1:0]                  chan_en;
    logic [NUM_CHAN-1:0][PORT_W-1:0]      cmd_base;
    logic [NUM_CHAN-1:0][PORT_W-1:0]      ctl_port;

    assign req = '{we: cfg_we, func: cfg_func, addr: cfg_addr, data: cfg_wdata};

    ide_cfg_store #(.PROGIF_INIT(PROGIF_INIT)) u_store (
        .clk       (clk),
        .rst       (rst),
        .req       (req),
        .cmd_q     (cmd_q),
        .stat_q    (stat_q),
        .progif_q  (progif_q),
        .native_q  (native_q),
        .scratch_q (scratch_q)
    );

    ide_cfg_rdmux u_rdmux (
        .func      (cfg_func),
        .addr      (cfg_addr),
        .cmd_q     (cmd_q),
        .stat_q    (stat_q),
        .progif_q  (progif_q),
        .scratch_q (scratch_q),
        .rdata     (cfg_rdata)
    );

    ide_chan_decode #(.CHAN_PRESENT(CHAN_PRESENT)) u_decode (
        .io_enable (cmd_q[CMD_IO_BIT]),
        .chan_en   (chan_en),
        .cmd_base  (cmd_base),
        .ctl_port  (ctl_port)
    );

    assign pri_en       = chan_en[0];
    assign sec_en       = chan_en[1];
    assign pri_cmd_base = cmd_base[0];
    assign sec_cmd_base = cmd_base[1];
    assign pri_ctl_port = ctl_port[0];
    assign sec_ctl_port = ctl_port[1];
    assign pri_native   = native_q[0];
    assign sec_native   = native_q[1];
endmodule

// File: rtl/ide_cfg_space_chk.sv
module ide_cfg_space_chk #(
    parameter logic [1:0] CHAN_PRESENT = 2'b11,
    parameter logic [7:0] PROGIF_INIT  = 8'h8A
) (
    input logic        clk,
    input logic        rst,
    input logic [2:0]  cfg_func,
    input logic [7:0]  cfg_addr,
    input logic [7:0]  cfg_wdata,
    input logic        cfg_we,
    input logic [7:0]  cfg_rdata,
    input logic        pri_en,
    input logic        sec_en,
    input logic [15:0] pri_cmd_base,
    input logic [15:0] sec_cmd_base,
    input logic        pri_native,
    input logic        sec_native
);
    localparam bit OPEN = ((PROGIF_INIT & 8'h0A) == 8'h0A);

    logic wr0;
    assign wr0 = cfg_we && (cfg_func == 3'd0);

    assert_func_ff_R3: assert property (@(posedge clk) disable iff (rst)
        (cfg_func != 3'd0) |-> (cfg_rdata == 8'hFF));

    assert_cmd_mask_R4: assert property (@(posedge clk) disable iff (rst)
        (cfg_func == 3'd0 && cfg_addr == 8'h04) |-> ((cfg_rdata & 8'hBE) == 8'h00));

    assert_en_follow_R11: assert property (@(posedge clk) disable iff (rst)
        (wr0 && cfg_addr == 8'h04) |=>
            (pri_en == (CHAN_PRESENT[0] && $past(cfg_wdata[0]))) &&
            (sec_en == (CHAN_PRESENT[1] && $past(cfg_wdata[0]))));

    assert_en_after_reset_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!pri_en && !sec_en && !pri_native && !sec_native));

    assert_absent_low_R12: assert property (@(posedge clk) disable iff (rst)
        (!CHAN_PRESENT[1] |-> !sec_en) and (!CHAN_PRESENT[0] |-> !pri_en));

    assert_bases_R10: assert property (@(posedge clk) disable iff (rst)
        (pri_cmd_base == 16'h01F0) && (sec_cmd_base == 16'h0170));

    assert_progif_locked_R6: assert property (@(posedge clk) disable iff (rst)
        (wr0 && cfg_addr == 8'h09 && !OPEN) |=> ($stable(pri_native) && $stable(sec_native)));

    assert_native_set_R7: assert property (@(posedge clk) disable iff (rst)
        (wr0 && cfg_addr == 8'h09 && OPEN) |=>
            (pri_native == $past(cfg_wdata[0])) && (sec_native == $past(cfg_wdata[2])));
endmodule

bind ide_cfg_space ide_cfg_space_chk #(
    .CHAN_PRESENT (CHAN_PRESENT),
    .PROGIF_INIT  (PROGIF_INIT)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .cfg_func     (cfg_func),
    .cfg_addr     (cfg_addr),
    .cfg_wdata    (cfg_wdata),
    .cfg_we       (cfg_we),
    .cfg_rdata    (cfg_rdata),
    .pri_en       (pri_en),
    .sec_en       (sec_en),
    .pri_cmd_base (pri_cmd_base),
    .sec_cmd_base (sec_cmd_base),
    .pri_native   (pri_native),
    .sec_native   (sec_native)
);

// File: tb/test_ide_cfg_space.sv
`timescale 1ns/1ps
module test_ide_cfg_space;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  cfg_func = '0;
    logic [7:0]  cfg_addr = '0;
    logic [7:0]  cfg_wdata = '0;
    logic        cfg_we = 1'b0;

    logic [7:0]  rd_a, rd_b;
    logic        pen_a, sen_a, pn_a, sn_a, pen_b, sen_b, pn_b, sn_b;
    logic [15:0] pcb_a, pcp_a, scb_a, scp_a, pcb_b, pcp_b, scb_b, scp_b;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    // Both channels, programming interface writable
    ide_cfg_space i_ide_cfg_space (
        .clk(clk), .rst(rst), .cfg_func(cfg_func), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_we(cfg_we), .cfg_rdata(rd_a),
        .pri_en(pen_a), .pri_cmd_base(pcb_a), .pri_ctl_port(pcp_a), .pri_native(pn_a),
        .sec_en(sen_a), .sec_cmd_base(scb_a), .sec_ctl_port(scp_a), .sec_native(sn_a));

    // Primary only, programming interface locked
    ide_cfg_space #(.CHAN_PRESENT(2'b01), .PROGIF_INIT(8'h00)) i_ide_cfg_space_lone (
        .clk(clk), .rst(rst), .cfg_func(cfg_func), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_we(cfg_we), .cfg_rdata(rd_b),
        .pri_en(pen_b), .pri_cmd_base(pcb_b), .pri_ctl_port(pcp_b), .pri_native(pn_b),
        .sec_en(sen_b), .sec_cmd_base(scb_b), .sec_ctl_port(scp_b), .sec_native(sn_b));

    typedef struct packed {
        logic       we;
        logic [2:0] wfunc;
        logic [7:0] addr;
        logic [7:0] wdata;
        logic [2:0] rfunc;
        logic [7:0] exp;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 3'd0, 8'h04, 8'hFF, 3'd0, 8'h41},  // R4 mask
        '{1'b1, 3'd0, 8'h07, 8'hFF, 3'd0, 8'h02},  // R5 W1C bit 7 only
        '{1'b1, 3'd0, 8'h09, 8'hFF, 3'd0, 8'h0F},  // R6 open, bit 7 dropped
        '{1'b1, 3'd0, 8'h09, 8'h00, 3'd0, 8'h0A},  // R6 capability bits kept
        '{1'b1, 3'd0, 8'h40, 8'hA5, 3'd0, 8'hA5},  // R8 low edge
        '{1'b1, 3'd0, 8'h4F, 8'h3C, 3'd0, 8'h3C},  // R8 high edge
        '{1'b1, 3'd0, 8'h4A, 8'h5A, 3'd0, 8'h5A},  // R8 middle
        '{1'b1, 3'd0, 8'h00, 8'hFF, 3'd0, 8'h42},  // R9 id byte
        '{1'b1, 3'd0, 8'h3C, 8'h00, 3'd0, 8'h0E},  // R9 line
        '{1'b1, 3'd0, 8'h50, 8'h77, 3'd0, 8'h00},  // R9 past window
        '{1'b1, 3'd0, 8'h3F, 8'h12, 3'd0, 8'h00},  // R9 below window
        '{1'b1, 3'd1, 8'h41, 8'h55, 3'd0, 8'h00},  // R3 other function write
        '{1'b0, 3'd0, 8'h00, 8'h00, 3'd2, 8'hFF},  // R3 other function read
        '{1'b1, 3'd0, 8'h04, 8'h00, 3'd0, 8'h00}   // R4 clear
    };

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] f, input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        cfg_func = f; cfg_addr = a; cfg_wdata = d; cfg_we = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic rd_setup(input logic [2:0] f, input logic [7:0] a);
        cfg_func = f; cfg_addr = a;
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        do_reset();

        // R1 identification and read-only bytes after reset
        rd_setup(0, 8'h00); chk("R1 0x00", rd_a, 8'h42);
        rd_setup(0, 8'h01); chk("R1 0x01", rd_a, 8'h10);
        rd_setup(0, 8'h02); chk("R1 0x02", rd_a, 8'h00);
        rd_setup(0, 8'h03); chk("R1 0x03", rd_a, 8'h10);
        rd_setup(0, 8'h04); chk("R1 0x04", rd_a, 8'h00);
        rd_setup(0, 8'h07); chk("R1 0x07", rd_a, 8'h02);
        rd_setup(0, 8'h08); chk("R1 0x08", rd_a, 8'h02);
        rd_setup(0, 8'h0A); chk("R1 0x0A", rd_a, 8'h01);
        rd_setup(0, 8'h0B); chk("R1 0x0B", rd_a, 8'h01);
        rd_setup(0, 8'h3C); chk("R1 0x3C", rd_a, 8'h0E);
        rd_setup(0, 8'h3D); chk("R1 0x3D", rd_a, 8'h01);
        rd_setup(0, 8'h45); chk("R1 0x45", rd_a, 8'h00);
        // R2 programming interface from parameter, flags clear
        rd_setup(0, 8'h09); chk("R2 progif a", rd_a, 8'h8A);
        chk("R2 progif b", rd_b, 8'h00);
        chk("R2 flags", {pn_a, sn_a, pn_b, sn_b}, 4'b0000);
        // R10 fixed port addresses
        chk("R10 pri cmd", pcb_a, 16'h01F0);
        chk("R10 pri ctl", pcp_a, 16'h03F6);
        chk("R10 sec cmd", scb_a, 16'h0170);
        chk("R10 sec ctl", scp_a, 16'h0376);
        chk("R11 enables off", {pen_a, sen_a}, 2'b00);

        // Vector table
        for (int i = 0; i < NV; i++) begin
            if (VECS[i].we) wr(VECS[i].wfunc, VECS[i].addr, VECS[i].wdata);
            else @(negedge clk);
            rd_setup(VECS[i].rfunc, VECS[i].addr);
            chk($sformatf("vector %0d addr 0x%0h", i, VECS[i].addr), rd_a, VECS[i].exp);
        end

        // R7 interrupt-mode flags follow data bits 0 and 2
        wr(0, 8'h09, 8'h01); #1;
        chk("R7 pri only", {pn_a, sn_a}, 2'b10);
        wr(0, 8'h09, 8'h04); #1;
        chk("R7 sec only", {pn_a, sn_a}, 2'b01);
        // R6 locked instance keeps byte and flags
        chk("R6 locked flags", {pn_b, sn_b}, 2'b00);
        rd_setup(0, 8'h09); chk("R6 locked byte", rd_b, 8'h00);

        // R11 / R12 enables
        wr(0, 8'h04, 8'h01); #1;
        chk("R11 both on", {pen_a, sen_a}, 2'b11);
        chk("R12 absent sec", {pen_b, sen_b}, 2'b10);
        wr(0, 8'h04, 8'h40); #1;
        chk("R11 bit6 only off", {pen_a, sen_a, pen_b}, 3'b000);
        wr(1, 8'h04, 8'h01); #1;
        chk("R3 func1 no enable", {pen_a, pen_b}, 2'b00);
        wr(0, 8'h04, 8'h01); #1;
        chk("R12 absent sec stays low", sen_b, 1'b0);

        // R1 reset after activity restores defaults
        do_reset();
        rd_setup(0, 8'h04); chk("R1 cmd after reset", rd_a, 8'h00);
        rd_setup(0, 8'h4A); chk("R1 scratch after reset", rd_a, 8'h00);
        rd_setup(0, 8'h09); chk("R2 progif after reset", rd_a, 8'h8A);
        chk("R2 flags after reset", {pn_a, sn_a, pen_a}, 3'b000);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule